// File: doc/BRIEF.md
# Graphic LCD Driver Command Controller

This block is the command and state core of a small graphic LCD driver. A serial-bus front end hands it one deserialized byte at a time, with a strobe and a flag that marks the byte as either an instruction or display data. Instruction bytes set the column pointer, the bank pointer, or the display-control state: power-down, addressing direction and a two-bit display mode. Each data byte becomes a one-cycle write to the display RAM at the current column/bank position. The pointers then step across a space of 101 columns by 5 banks, either column-first or bank-first.

After the asynchronous reset input is released, an internal synchronous reset holds the block for two clock edges. During that time every strobe is dropped. The block then comes up powered down, with the bias generator and the oscillator disabled. Instructions and data writes are still accepted while the block is powered down, so software can load the RAM before it turns the panel on.

Top module: `lcd_cmd_core`

## Requirements
- R1: While `rst_n` is low, and on the first two rising clock edges after it is released, every strobe is ignored. During that time `pwr_down`=1, `disp_mode`=0, `wr_en`=0, `bias_en`=0 and `osc_en`=0. A strobe on the third edge after release is accepted.
- R2: When the synchronous reset completes, the block is powered down (`pwr_down`=1), both pointers are 0, the display mode is blank and horizontal addressing is selected.
- R3: The instruction byte `001PVxMM` (bits 7..5 = 001) updates the control state in the next cycle. Bit 4 sets power-down. Bit 3 selects the addressing direction (0 horizontal, 1 vertical). Bits 1..0 set `disp_mode`: 0 blank, 1 normal, 2 all segments on, 3 inverse video. Bit 2 is ignored.
- R4: `bias_en` and `osc_en` are both 0 whenever `pwr_down` is 1, and both 1 whenever it is 0.
- R5: Instructions and data writes are decoded and carried out while `pwr_down` is 1.
- R6: The instruction byte `1XXXXXXX` loads the column pointer from bits 6..0 if that value is at most 100. A value of 101 to 127 leaves the column pointer unchanged.
- R7: The instruction byte `01000YYY` loads the bank pointer from bits 2..0 if that value is at most 4. A value of 5 to 7 leaves the bank pointer unchanged.
- R8: A data byte accepted on an edge gives `wr_en`=1 for exactly the next cycle. In that cycle `wr_col`, `wr_bank` and `wr_data` show the pointer values in force before the write and the byte itself.
- R9: In horizontal mode, a write advances the column. Past column 100 the column returns to 0 and the bank advances, and the bank returns from 4 to 0.
- R10: In vertical mode, a write advances the bank. Past bank 4 the bank returns to 0 and the column advances, and the column returns from 100 to 0.
- R11: An instruction byte matching none of the three patterns (for example `00000000`, `00011111`, `01001000`, `01111111`) changes neither the pointers nor the control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| byte_valid | input | 1 | Strobe: a byte is present this cycle |
| byte_is_data | input | 1 | 1 = display data, 0 = instruction |
| byte_in | input | 8 | Deserialized byte |
| disp_mode | output | 2 | Display mode (0 blank, 1 normal, 2 all on, 3 inverse) |
| pwr_down | output | 1 | Power-down state |
| bias_en | output | 1 | Bias generator enable |
| osc_en | output | 1 | Internal oscillator enable |
| wr_en | output | 1 | Display RAM write enable, one cycle per data byte |
| wr_col | output | 7 | Column address of the write |
| wr_bank | output | 3 | Bank address of the write |
| wr_data | output | 8 | Data of the write |

## Verification
On every cycle the assertions check the following:
- Both pointers stay inside the 101 by 5 space.
- A rejected column or bank value leaves its pointer untouched.
- Each write steps the pointers by exactly one position in the selected direction.
- A write pulse never follows an edge on which the block was still in reset.
- Control is powered down as the reset completes.

Only the bench scenarios can show several other things: the exact wrap positions at the corners (column 100, bank 4), the order of writes across a row or column boundary, and that unknown bytes and strobes during the reset window have no visible effect. They also show that writes issued while powered down land at the expected addresses.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_BLANK   = 2'd0,
    MODE_NORMAL  = 2'd1,
    MODE_ALL_ON  = 2'd2,
    MODE_INVERSE = 2'd3
  } disp_mode_e;

  localparam logic [2:0] CTL_PREFIX  = 3'b001;
  localparam logic [4:0] BANK_PREFIX = 5'b01000;

  typedef struct packed {
    logic       pd;
    logic       vert;
    disp_mode_e mode;
  } ctl_t;

endpackage

// File: rtl/lcd_rst_seq.sv
module lcd_rst_seq #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ready = sh_q[STAGES-1];

endmodule

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
  import lcd_cmd_pkg::*;
#(
  parameter int COL_MAX  = 100,
  parameter int BANK_MAX = 4,
  localparam int COL_W   = $clog2(COL_MAX + 1),
  localparam int BANK_W  = $clog2(BANK_MAX + 1)
) (
  input  logic              accept,
  input  logic              byte_valid,
  input  logic              byte_is_data,
  input  logic [7:0]        byte_in,
  output logic              do_write,
  output logic              ld_col,
  output logic [COL_W-1:0]  col_val,
  output logic              ld_bank,
  output logic [BANK_W-1:0] bank_val,
  output logic              ld_ctl,
  output ctl_t              ctl_val
);

  logic take;
  logic is_col, is_bank, is_ctl;

  always_comb begin
    take     = accept && byte_valid;
    is_col   = byte_in[7];
    is_bank  = (byte_in[7:3] == BANK_PREFIX);
    is_ctl   = (byte_in[7:5] == CTL_PREFIX);
    do_write = take && byte_is_data;
    ld_col   = take && !byte_is_data && is_col &&
               (int'(byte_in[6:0]) <= COL_MAX);
    ld_bank  = take && !byte_is_data && is_bank &&
               (int'(byte_in[2:0]) <= BANK_MAX);
    ld_ctl   = take && !byte_is_data && is_ctl;
    col_val  = COL_W'(byte_in[6:0]);
    bank_val = BANK_W'(byte_in[2:0]);
    ctl_val.pd   = byte_in[4];
    ctl_val.vert = byte_in[3];
    ctl_val.mode = disp_mode_e'(byte_in[1:0]);
  end

  always_comb begin
    a_excl_r11: assert ($onehot0({do_write, ld_col, ld_bank, ld_ctl}))
      else $error("decode strobes overlap");
  end

endmodule

// File: rtl/lcd_addr_ptr.sv
module lcd_addr_ptr #(
  parameter int COL_MAX  = 100,
  parameter int BANK_MAX = 4,
  localparam int COL_W   = $clog2(COL_MAX + 1),
  localparam int BANK_W  = $clog2(BANK_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ld_col,
  input  logic [COL_W-1:0]  col_val,
  input  logic              ld_bank,
  input  logic [BANK_W-1:0] bank_val,
  input  logic              step,
  input  logic              vert,
  output logic [COL_W-1:0]  col,
  output logic [BANK_W-1:0] bank
);

  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COL_MAX);
  localparam logic [BANK_W-1:0] BANK_LAST = BANK_W'(BANK_MAX);

  logic [COL_W-1:0]  col_q, col_d, col_inc;
  logic [BANK_W-1:0] bank_q, bank_d, bank_inc;
  logic              col_wrap, bank_wrap;

  always_comb begin
    col_wrap  = (col_q == COL_LAST);
    bank_wrap = (bank_q == BANK_LAST);
    col_inc   = col_wrap  ? '0 : col_q + COL_W'(1);
    bank_inc  = bank_wrap ? '0 : bank_q + BANK_W'(1);
    col_d     = col_q;
    bank_d    = bank_q;
    if (clr) begin
      col_d  = '0;
      bank_d = '0;
    end else if (ld_col) begin
      col_d = col_val;
    end else if (ld_bank) begin
      bank_d = bank_val;
    end else if (step) begin
      if (!vert) begin
        col_d = col_inc;
        if (col_wrap) bank_d = bank_inc;
      end else begin
        bank_d = bank_inc;
        if (bank_wrap) col_d = col_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      bank_q <= '0;
    end else begin
      col_q  <= col_d;
      bank_q <= bank_d;
    end
  end

  assign col  = col_q;
  assign bank = bank_q;

  p_col_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col_q) <= COL_MAX);

  p_bank_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bank_q) <= BANK_MAX);

  p_hstep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !vert && col_q != COL_LAST) |=>
      (int'(col_q) == int'($past(col_q)) + 1) && $stable(bank_q));

  p_vstep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && vert && bank_q != BANK_LAST) |=>
      (int'(bank_q) == int'($past(bank_q)) + 1) && $stable(col_q));

endmodule

// File: rtl/lcd_cmd_core.sv
module lcd_cmd_core
  import lcd_cmd_pkg::*;
#(
  parameter int COL_MAX    = 100,
  parameter int BANK_MAX   = 4,
  parameter int RST_STAGES = 2,
  localparam int COL_W     = $clog2(COL_MAX + 1),
  localparam int BANK_W    = $clog2(BANK_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic              byte_is_data,
  input  logic [7:0]        byte_in,
  output logic [1:0]        disp_mode,
  output logic              pwr_down,
  output logic              bias_en,
  output logic              osc_en,
  output logic              wr_en,
  output logic [COL_W-1:0]  wr_col,
  output logic [BANK_W-1:0] wr_bank,
  output logic [7:0]        wr_data
);

  logic              ready;
  logic              do_write, ld_col, ld_bank, ld_ctl;
  logic [COL_W-1:0]  col_val, col;
  logic [BANK_W-1:0] bank_val, bank;
  ctl_t              ctl_val, ctl_q, ctl_d;
  logic              wr_en_d;

  lcd_rst_seq #(.STAGES(RST_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (ready)
  );

  lcd_cmd_decode #(.COL_MAX(COL_MAX), .BANK_MAX(BANK_MAX)) u_dec (
    .accept       (ready),
    .byte_valid   (byte_valid),
    .byte_is_data (byte_is_data),
    .byte_in      (byte_in),
    .do_write     (do_write),
    .ld_col       (ld_col),
    .col_val      (col_val),
    .ld_bank      (ld_bank),
    .bank_val     (bank_val),
    .ld_ctl       (ld_ctl),
    .ctl_val      (ctl_val)
  );

  lcd_addr_ptr #(.COL_MAX(COL_MAX), .BANK_MAX(BANK_MAX)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!ready),
    .ld_col   (ld_col),
    .col_val  (col_val),
    .ld_bank  (ld_bank),
    .bank_val (bank_val),
    .step     (do_write),
    .vert     (ctl_q.vert),
    .col      (col),
    .bank     (bank)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (!ready) begin
      ctl_d.pd   = 1'b1;
      ctl_d.vert = 1'b0;
      ctl_d.mode = MODE_BLANK;
    end else if (ld_ctl) begin
      ctl_d = ctl_val;
    end
    wr_en_d = do_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.pd   <= 1'b1;
      ctl_q.vert <= 1'b0;
      ctl_q.mode <= MODE_BLANK;
      wr_en      <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      wr_en <= wr_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_col  <= '0;
      wr_bank <= '0;
      wr_data <= '0;
    end else if (do_write) begin
      wr_col  <= col;
      wr_bank <= bank;
      wr_data <= byte_in;
    end
  end

  assign disp_mode = ctl_q.mode;
  assign pwr_down  = ctl_q.pd;
  assign bias_en   = !ctl_q.pd;
  assign osc_en    = !ctl_q.pd;

  p_pd_on_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> pwr_down && col == '0 && bank == '0);

  p_no_early_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(ready));

  p_write_in_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && byte_valid && byte_is_data && pwr_down) |=> wr_en);

  p_bad_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && byte_valid && !byte_is_data && byte_in[7] &&
     int'(byte_in[6:0]) > COL_MAX) |=> $stable(col));

  p_bad_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && byte_valid && !byte_is_data && byte_in[7:3] == BANK_PREFIX &&
     int'(byte_in[2:0]) > BANK_MAX) |=> $stable(bank));

endmodule

// File: tb/tb_lcd_cmd_core.sv
module tb_lcd_cmd_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_valid = 1'b0;
  logic       byte_is_data = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [1:0] disp_mode;
  logic       pwr_down, bias_en, osc_en, wr_en;
  logic [6:0] wr_col;
  logic [2:0] wr_bank;
  logic [7:0] wr_data;

  lcd_cmd_core dut (
    .clk (clk), .rst_n (rst_n), .byte_valid (byte_valid),
    .byte_is_data (byte_is_data), .byte_in (byte_in),
    .disp_mode (disp_mode), .pwr_down (pwr_down), .bias_en (bias_en),
    .osc_en (osc_en), .wr_en (wr_en), .wr_col (wr_col),
    .wr_bank (wr_bank), .wr_data (wr_data)
  );

  always #5 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_tag = "R1";
  bit    cmp_on  = 1'b0;
  bit    done    = 1'b0;

  int m_edges, m_pd, m_v, m_mode, m_col, m_bank, m_wr, m_wcol, m_wbank, m_wdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edges = 0; m_pd = 1; m_v = 0; m_mode = 0; m_col = 0; m_bank = 0;
      m_wr = 0; m_wcol = 0; m_wbank = 0; m_wdata = 0;
    end else begin
      bit ok;
      int idx;
      ok = (m_edges >= 2);
      if (m_edges < 3) m_edges++;
      m_wr = 0;
      if (ok && byte_valid) begin
        if (byte_is_data) begin
          m_wr = 1; m_wcol = m_col; m_wbank = m_bank; m_wdata = byte_in;
          if (m_v == 0) begin
            idx = (m_bank * 101 + m_col + 1) % 505;
            m_bank = idx / 101; m_col = idx % 101;
          end else begin
            idx = (m_col * 5 + m_bank + 1) % 505;
            m_col = idx / 5; m_bank = idx % 5;
          end
        end else if (byte_in[7]) begin
          if (byte_in[6:0] <= 100) m_col = byte_in[6:0];
        end else if (byte_in[7:3] == 5'b01000) begin
          if (byte_in[2:0] <= 4) m_bank = byte_in[2:0];
        end else if (byte_in[7:5] == 3'b001) begin
          m_pd = byte_in[4]; m_v = byte_in[3]; m_mode = byte_in[1:0];
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk({cur_tag, " pwr_down"}, pwr_down, m_pd);
      chk({cur_tag, " mode"}, disp_mode, m_mode);
      chk("R4 bias_en", bias_en, m_pd ? 0 : 1);
      chk("R4 osc_en", osc_en, m_pd ? 0 : 1);
      chk({cur_tag, " wr_en"}, wr_en, m_wr);
      chk({cur_tag, " wr_col"}, wr_col, m_wcol);
      chk({cur_tag, " wr_bank"}, wr_bank, m_wbank);
      chk({cur_tag, " wr_data"}, wr_data, m_wdata);
    end
  end

  task automatic send(bit is_data, logic [7:0] b);
    byte_valid = 1'b1; byte_is_data = is_data; byte_in = b;
    @(negedge clk);
    byte_valid = 1'b0; byte_is_data = 1'b0; byte_in = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #150000;
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset window
    idle(3);
    cmp_on = 1'b1;
    chk("R1 pwr_down in reset", pwr_down, 1);
    chk("R1 osc_en in reset", osc_en, 0);
    rst_n = 1'b1;
    send(1'b0, 8'h21);          // edge 1: ignored
    send(1'b1, 8'hA5);          // edge 2: ignored
    chk("R1 ctl ignored", pwr_down, 1);
    chk("R1 write ignored", wr_en, 0);

    // R2: state after reset
    cur_tag = "R2";
    chk("R2 pwr_down", pwr_down, 1);
    chk("R2 mode blank", disp_mode, 0);
    send(1'b1, 8'h11);
    chk("R2 col 0", wr_col, 0);
    chk("R2 bank 0", wr_bank, 0);
    chk("R8 wr_en pulse", wr_en, 1);
    chk("R8 wr_data", wr_data, 8'h11);
    idle(1);
    chk("R8 single pulse", wr_en, 0);

    // R5: work while powered down
    cur_tag = "R5";
    send(1'b0, 8'h8A);          // col 10
    send(1'b0, 8'h42);          // bank 2
    send(1'b1, 8'h3C);
    chk("R5 col while PD", wr_col, 10);
    chk("R5 bank while PD", wr_bank, 2);

    // R3/R4: control
    cur_tag = "R3";
    send(1'b0, 8'h21); idle(1);
    chk("R3 normal mode", disp_mode, 1);
    chk("R4 bias on", bias_en, 1);
    send(1'b0, 8'h26); idle(1);  // bit2 ignored, mode all on
    chk("R3 all on", disp_mode, 2);
    send(1'b0, 8'h33); idle(1);
    chk("R3 inverse", disp_mode, 3);
    chk("R4 osc off", osc_en, 0);
    send(1'b0, 8'h20); idle(1);
    chk("R3 blank", disp_mode, 0);

    // R6: column load and rejection
    cur_tag = "R6";
    send(1'b0, 8'hE4);          // 100
    send(1'b0, 8'hE5);          // 101 rejected
    send(1'b0, 8'hFF);          // 127 rejected
    send(1'b1, 8'h01);
    chk("R6 col kept at 100", wr_col, 100);

    // R7: bank load and rejection
    cur_tag = "R7";
    send(1'b0, 8'h43);
    send(1'b0, 8'h45);
    send(1'b0, 8'h47);
    send(1'b1, 8'h02);
    chk("R7 bank kept at 3", wr_bank, 3);

    // R9: horizontal wrap
    cur_tag = "R9";
    send(1'b0, 8'h21);
    send(1'b0, 8'hE3);          // col 99
    send(1'b0, 8'h44);          // bank 4
    send(1'b1, 8'h10);
    send(1'b1, 8'h11);
    chk("R9 col 100", wr_col, 100);
    send(1'b1, 8'h12);
    chk("R9 wrap col", wr_col, 0);
    chk("R9 wrap bank", wr_bank, 0);
    send(1'b0, 8'hE4);
    send(1'b0, 8'h41);
    send(1'b1, 8'h13);
    send(1'b1, 8'h14);
    chk("R9 next bank col", wr_col, 0);
    chk("R9 next bank", wr_bank, 2);

    // R10: vertical wrap
    cur_tag = "R10";
    send(1'b0, 8'h29);
    send(1'b0, 8'hE4);
    send(1'b0, 8'h43);
    send(1'b1, 8'h20);
    send(1'b1, 8'h21);
    chk("R10 bank 4", wr_bank, 4);
    send(1'b1, 8'h22);
    chk("R10 wrap col", wr_col, 0);
    chk("R10 wrap bank", wr_bank, 0);
    send(1'b0, 8'h85);
    send(1'b0, 8'h44);
    send(1'b1, 8'h23);
    send(1'b1, 8'h24);
    chk("R10 col advance", wr_col, 6);
    chk("R10 bank reset", wr_bank, 0);

    // R11: unknown instruction bytes
    cur_tag = "R11";
    send(1'b0, 8'h00);
    send(1'b0, 8'h1F);
    send(1'b0, 8'h48);
    send(1'b0, 8'h7F);
    idle(1);
    chk("R11 mode kept", disp_mode, 1);
    chk("R11 pd kept", pwr_down, 0);
    send(1'b1, 8'h55);
    chk("R11 col kept", wr_col, 6);
    chk("R11 bank kept", wr_bank, 1);

    // R1: reset in mid-run, applied off the clock edge
    cur_tag = "R1";
    #3 rst_n = 1'b0;
    @(negedge clk);
    chk("R1 async pd", pwr_down, 1);
    chk("R1 async bias", bias_en, 0);
    rst_n = 1'b1;
    send(1'b0, 8'h21);
    send(1'b0, 8'h21);
    send(1'b0, 8'h21);          // third edge accepted
    idle(1);
    chk("R1 third edge accepted", pwr_down, 0);
    idle(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule